// File: doc/BRIEF.md
# Byte-Port DMA Channel Registers

This block is the programming face of one DMA channel, reached over an 8-bit port bus. The host loads a 16-bit transfer address and a 16-bit count one byte at a time. Both go through one shared byte-pointer flip-flop that a write to a dedicated clear port resets. Two page ports supply address bits 23:16 and 31:24. The count is programmed as the number of bytes minus one. A mode port picks the transfer direction, a mask port enables or disables the channel, and a status port reports the terminal-count flag.

Once the channel is unmasked and holds a valid direction, a device request raises a memory-side request carrying the full 32-bit address. Each cycle the memory side acknowledges is one transfer step: the address counts up and the count counts down. The step that takes the count from zero to 0xFFFF is terminal count. It sets the status flag, pulses an output and masks the channel again.

Top module: `dma_chan_regs`

## Requirements
- R1: After reset the address and count both read 0x0000, the status port reads 0x00, and the channel is masked, so `mem_req` stays low even when `dreq` is high.
- R2: A write to the flip-flop clear port (select 6) points the byte pointer at the low byte. Every access to the address port (select 0) or the count port (select 1) then alternates low byte, high byte. The two ports share this one pointer.
- R3: Reads of the address and count ports return the current value, low byte then high byte, and advance the same pointer that writes use.
- R4: The page-low port (select 2) holds `mem_addr[23:16]` and the page-high port (select 3) holds `mem_addr[31:24]`. Both read back what was written.
- R5: A mode write (select 4) is taken only when bits 1:0 equal the channel number (2). In the accepted byte, bits 3:2 = 01 selects device-to-memory (`mem_wr`=1, e.g. 0x46) and bits 3:2 = 10 selects memory-to-device (`mem_wr`=0, e.g. 0x4A). The values 00 and 11 serve no requests.
- R6: A mask write (select 5) with bits 1:0 equal to 2 unmasks the channel when bit 2 is 0 and masks it when bit 2 is 1. A mask write naming another channel has no effect.
- R7: With the channel unmasked, a valid direction and `dreq` high, `mem_req` is high and `mem_addr` = {page high, page low, address}. Each cycle with `mem_req` and `mem_ack` both high is a step: `dack` pulses, the address increments modulo 2^16 without touching the pages, and the count decrements.
- R8: A step taken while the count is 0 is terminal count. `tc` pulses in that cycle, the count becomes 0xFFFF, status bit 2 sets and the channel masks itself. A programmed count N therefore moves N+1 bytes.
- R9: A status read (select 7) returns the terminal-count flags in bits 3:0: only bit 2 is used, and bits 7:4 read 0. The read clears the flags. A terminal count in the same cycle as the read is not shown by that read but stays set for the next one.
- R10: In any cycle the host reads or writes the address or count port, `mem_req` is low and no step takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| port_sel | input | 3 | Register port select |
| port_wr | input | 1 | Port write strobe |
| port_rd | input | 1 | Port read strobe |
| port_wdata | input | 8 | Write data |
| port_rdata | output | 8 | Read data for the selected port |
| dreq | input | 1 | Device transfer request |
| dack | output | 1 | Step acknowledge to the device |
| mem_req | output | 1 | Memory-side request |
| mem_wr | output | 1 | 1 = device-to-memory, 0 = memory-to-device |
| mem_addr | output | 32 | Full transfer address |
| mem_ack | input | 1 | Memory side accepts the current step |
| tc | output | 1 | Terminal-count pulse |

## Verification
The status read and a terminal-count step can land in the same clock. In that case the flag must not be lost to the read-clear. The bench provokes this by raising `mem_ack` on the last programmed byte while the host reads the status port in that same cycle. It then expects the read to return 0x00 with `tc` and `dack` high, the next status read to return 0x04, and the read after that to return 0x00. A second overlap is a host write to the count port while `mem_ack` is held high. There, `mem_req` must drop and the count must keep exactly the host's value.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

  typedef enum logic [2:0] {
    PORT_ADDR     = 3'd0,
    PORT_COUNT    = 3'd1,
    PORT_PAGE_LO  = 3'd2,
    PORT_PAGE_HI  = 3'd3,
    PORT_MODE     = 3'd4,
    PORT_MASK     = 3'd5,
    PORT_FLIP_CLR = 3'd6,
    PORT_STATUS   = 3'd7
  } port_sel_e;

  typedef enum logic [1:0] {
    XFER_CHECK     = 2'b00,
    XFER_TO_MEM    = 2'b01,
    XFER_FROM_MEM  = 2'b10,
    XFER_RESERVED  = 2'b11
  } xfer_e;

  // next value of a stepping register
  function automatic logic [31:0] f_step(input logic [31:0] v, input logic up);
    return up ? v + 32'd1 : v - 32'd1;
  endfunction

  // a step from this value leaves the word's range
  function automatic logic f_wraps(input logic [31:0] v, input int width, input logic up);
    logic [31:0] top;
    top = (32'd1 << width) - 32'd1;
    return up ? (v == top) : (v == 32'd0);
  endfunction

  function automatic logic f_chan_hit(input logic [1:0] field, input int chan);
    return field == chan[1:0];
  endfunction

  function automatic logic f_serves(input xfer_e x);
    return (x == XFER_TO_MEM) || (x == XFER_FROM_MEM);
  endfunction

endpackage

// File: rtl/dma_byte_ptr.sv
module dma_byte_ptr (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic toggle,
  output logic hi_sel
);

  always_ff @(posedge clk) begin
    if (!rst_n)      hi_sel <= 1'b0;
    else if (clr)    hi_sel <= 1'b0;
    else if (toggle) hi_sel <= ~hi_sel;
  end

  p_clear_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !hi_sel);

  p_alternate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (toggle && !clr) |=> (hi_sel != $past(hi_sel)));

endmodule

// File: rtl/dma_word_reg.sv
module dma_word_reg #(
  parameter int BYTE_W  = 8,
  parameter int COUNT_UP = 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_lo,
  input  logic                  wr_hi,
  input  logic [BYTE_W-1:0]     wdata,
  input  logic                  step,
  output logic [2*BYTE_W-1:0]   value,
  output logic                  wrap
);
  import dma_chan_pkg::*;

  localparam int WORD_W = 2 * BYTE_W;

  logic [WORD_W-1:0] next_val;

  generate
    if (COUNT_UP != 0) begin : g_up
      assign next_val = WORD_W'(f_step(32'(value), 1'b1));
      assign wrap     = f_wraps(32'(value), WORD_W, 1'b1);
    end else begin : g_down
      assign next_val = WORD_W'(f_step(32'(value), 1'b0));
      assign wrap     = f_wraps(32'(value), WORD_W, 1'b0);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n)     value <= '0;
    else if (wr_lo) value[BYTE_W-1:0] <= wdata;
    else if (wr_hi) value[WORD_W-1:BYTE_W] <= wdata;
    else if (step)  value <= next_val;
  end

  p_step_moves_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !wr_lo && !wr_hi) |=> (value != $past(value)));

  p_write_one_byte_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> (value[WORD_W-1:BYTE_W] == $past(value[WORD_W-1:BYTE_W])));

endmodule

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl #(
  parameter int CHAN   = 2,
  parameter int FLAG_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_wr,
  input  logic [3:0]        mode_bits,
  input  logic              mask_wr,
  input  logic [2:0]        mask_bits,
  input  logic              tc_evt,
  input  logic              status_rd,
  output logic              masked,
  output dma_chan_pkg::xfer_e xfer,
  output logic [FLAG_W-1:0] flags
);
  import dma_chan_pkg::*;

  logic mode_hit, mask_hit;
  assign mode_hit = mode_wr && f_chan_hit(mode_bits[1:0], CHAN);
  assign mask_hit = mask_wr && f_chan_hit(mask_bits[1:0], CHAN);

  always_ff @(posedge clk) begin
    if (!rst_n)        xfer <= XFER_CHECK;
    else if (mode_hit) xfer <= xfer_e'(mode_bits[3:2]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        masked <= 1'b1;
    else if (tc_evt)   masked <= 1'b1;
    else if (mask_hit) masked <= mask_bits[2];
  end

  generate
    for (genvar i = 0; i < FLAG_W; i++) begin : g_flag
      if (i == CHAN) begin : g_live
        logic f_q;
        always_ff @(posedge clk) begin
          if (!rst_n)         f_q <= 1'b0;
          else if (tc_evt)    f_q <= 1'b1;
          else if (status_rd) f_q <= 1'b0;
        end
        assign flags[i] = f_q;
      end else begin : g_tied
        assign flags[i] = 1'b0;
      end
    end
  endgenerate

  p_tc_masks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tc_evt |=> masked);

  p_tc_flag_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tc_evt |=> flags[CHAN]);

  p_read_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (status_rd && !tc_evt) |=> (flags == '0));

  p_foreign_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_wr && !mask_hit && !tc_evt) |=> $stable(masked));

endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs #(
  parameter int CHAN   = 2,
  parameter int BYTE_W = 8,
  parameter int FLAG_W = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2:0]          port_sel,
  input  logic                port_wr,
  input  logic                port_rd,
  input  logic [BYTE_W-1:0]   port_wdata,
  output logic [BYTE_W-1:0]   port_rdata,
  input  logic                dreq,
  output logic                dack,
  output logic                mem_req,
  output logic                mem_wr,
  output logic [4*BYTE_W-1:0] mem_addr,
  input  logic                mem_ack,
  output logic                tc
);
  import dma_chan_pkg::*;

  localparam int WORD_W = 2 * BYTE_W;

  port_sel_e sel;
  assign sel = port_sel_e'(port_sel);

  logic hi_sel, flip_clr, word_access;
  logic addr_wr, cnt_wr;
  logic [WORD_W-1:0] addr_q, cnt_q;
  logic addr_wrap, cnt_wrap;
  logic [BYTE_W-1:0] page_lo, page_hi;
  logic masked;
  xfer_e xfer;
  logic [FLAG_W-1:0] flags;
  logic step_evt, tc_evt, status_rd;

  // host events
  assign flip_clr    = port_wr && (sel == PORT_FLIP_CLR);
  assign word_access = (port_wr || port_rd) && ((sel == PORT_ADDR) || (sel == PORT_COUNT));
  assign addr_wr     = port_wr && (sel == PORT_ADDR);
  assign cnt_wr      = port_wr && (sel == PORT_COUNT);
  assign status_rd   = port_rd && (sel == PORT_STATUS);

  // transfer events
  assign mem_req  = !masked && dreq && f_serves(xfer) && !word_access;
  assign step_evt = mem_req && mem_ack;
  assign tc_evt   = step_evt && cnt_wrap;
  assign dack     = step_evt;
  assign tc       = tc_evt;
  assign mem_wr   = (xfer == XFER_TO_MEM);
  assign mem_addr = {page_hi, page_lo, addr_q};

  dma_byte_ptr u_ptr (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (flip_clr),
    .toggle (word_access),
    .hi_sel (hi_sel)
  );

  dma_word_reg #(.BYTE_W(BYTE_W), .COUNT_UP(1)) u_addr (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_lo (addr_wr && !hi_sel),
    .wr_hi (addr_wr && hi_sel),
    .wdata (port_wdata),
    .step  (step_evt),
    .value (addr_q),
    .wrap  (addr_wrap)
  );

  dma_word_reg #(.BYTE_W(BYTE_W), .COUNT_UP(0)) u_count (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_lo (cnt_wr && !hi_sel),
    .wr_hi (cnt_wr && hi_sel),
    .wdata (port_wdata),
    .step  (step_evt),
    .value (cnt_q),
    .wrap  (cnt_wrap)
  );

  dma_chan_ctrl #(.CHAN(CHAN), .FLAG_W(FLAG_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_wr   (port_wr && (sel == PORT_MODE)),
    .mode_bits (port_wdata[3:0]),
    .mask_wr   (port_wr && (sel == PORT_MASK)),
    .mask_bits (port_wdata[2:0]),
    .tc_evt    (tc_evt),
    .status_rd (status_rd),
    .masked    (masked),
    .xfer      (xfer),
    .flags     (flags)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      page_lo <= '0;
      page_hi <= '0;
    end else if (port_wr) begin
      if (sel == PORT_PAGE_LO) page_lo <= port_wdata;
      if (sel == PORT_PAGE_HI) page_hi <= port_wdata;
    end
  end

  always_comb begin
    port_rdata = '0;
    case (sel)
      PORT_ADDR:    port_rdata = hi_sel ? addr_q[WORD_W-1:BYTE_W] : addr_q[BYTE_W-1:0];
      PORT_COUNT:   port_rdata = hi_sel ? cnt_q[WORD_W-1:BYTE_W]  : cnt_q[BYTE_W-1:0];
      PORT_PAGE_LO: port_rdata = page_lo;
      PORT_PAGE_HI: port_rdata = page_hi;
      PORT_STATUS:  port_rdata = BYTE_W'(flags);
      default:      port_rdata = '0;
    endcase
  end

  p_host_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
    word_access |-> !mem_req);

  p_addr_up_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (step_evt && !addr_wr) |=> (addr_q == WORD_W'($past(addr_q) + 1'b1)));

  p_page_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (step_evt && !port_wr) |=> $stable(mem_addr[4*BYTE_W-1:WORD_W]));

  p_tc_reload_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tc_evt |=> (cnt_q == '1));

  p_masked_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tc_evt |=> !mem_req);

  p_addr_wrap_seen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (step_evt && addr_wrap && !addr_wr) |=> (addr_q == '0));

endmodule

// File: tb/dma_chan_regs_test.sv
module dma_chan_regs_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] port_sel = '0;
  logic port_wr = 1'b0, port_rd = 1'b0;
  logic [7:0] port_wdata = '0;
  logic [7:0] port_rdata;
  logic dreq = 1'b0, mem_ack = 1'b0;
  logic dack, mem_req, mem_wr, tc;
  logic [31:0] mem_addr;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  dma_chan_regs uut (
    .clk(clk), .rst_n(rst_n), .port_sel(port_sel), .port_wr(port_wr),
    .port_rd(port_rd), .port_wdata(port_wdata), .port_rdata(port_rdata),
    .dreq(dreq), .dack(dack), .mem_req(mem_req), .mem_wr(mem_wr),
    .mem_addr(mem_addr), .mem_ack(mem_ack), .tc(tc)
  );

  localparam logic [2:0] S_ADDR = 3'd0, S_CNT = 3'd1, S_PLO = 3'd2, S_PHI = 3'd3,
                         S_MODE = 3'd4, S_MASK = 3'd5, S_FLIP = 3'd6, S_STAT = 3'd7;
  localparam logic [1:0] OP_W = 2'd0, OP_R = 2'd1;

  // {op, sel, wdata, expected read}
  localparam int NVEC = 26;
  localparam logic [20:0] VEC [0:NVEC-1] = '{
    {OP_W, S_FLIP, 8'h00, 8'h00},
    {OP_W, S_ADDR, 8'h34, 8'h00},
    {OP_W, S_ADDR, 8'h12, 8'h00},
    {OP_W, S_CNT,  8'h03, 8'h00},
    {OP_W, S_CNT,  8'h00, 8'h00},
    {OP_R, S_ADDR, 8'h00, 8'h34},
    {OP_R, S_ADDR, 8'h00, 8'h12},
    {OP_R, S_CNT,  8'h00, 8'h03},
    {OP_R, S_CNT,  8'h00, 8'h00},
    {OP_W, S_FLIP, 8'h00, 8'h00},
    {OP_W, S_ADDR, 8'h78, 8'h00},
    {OP_W, S_CNT,  8'h56, 8'h00},
    {OP_W, S_FLIP, 8'h00, 8'h00},
    {OP_R, S_ADDR, 8'h00, 8'h78},
    {OP_R, S_ADDR, 8'h00, 8'h12},
    {OP_R, S_CNT,  8'h00, 8'h03},
    {OP_R, S_CNT,  8'h00, 8'h56},
    {OP_W, S_FLIP, 8'h00, 8'h00},
    {OP_W, S_CNT,  8'h03, 8'h00},
    {OP_W, S_CNT,  8'h00, 8'h00},
    {OP_W, S_PLO,  8'hAB, 8'h00},
    {OP_W, S_PHI,  8'hCD, 8'h00},
    {OP_R, S_PLO,  8'h00, 8'hAB},
    {OP_R, S_PHI,  8'h00, 8'hCD},
    {OP_R, S_STAT, 8'h00, 8'h00},
    {OP_R, S_FLIP, 8'h00, 8'h00}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr_port(input logic [2:0] s, input logic [7:0] d);
    @(negedge clk);
    port_sel = s; port_wdata = d; port_wr = 1'b1;
    @(posedge clk); #1;
    port_wr = 1'b0;
  endtask

  task automatic rd_port(input logic [2:0] s, input logic [7:0] exp, input string tag);
    @(negedge clk);
    port_sel = s; port_rd = 1'b1;
    #1 chk(tag, 32'(port_rdata), 32'(exp));
    @(posedge clk); #1;
    port_rd = 1'b0;
  endtask

  task automatic step_once(input string tag);
    @(negedge clk);
    mem_ack = 1'b1;
    #1 chk(tag, 32'(dack), 32'd1);
    @(posedge clk); #1;
    mem_ack = 1'b0;
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    dreq = 1'b1;

    // R1 reset state
    @(negedge clk); chk("R1 mem_req masked", 32'(mem_req), 0);
    rd_port(S_ADDR, 8'h00, "R1 addr lo");
    rd_port(S_ADDR, 8'h00, "R1 addr hi");
    rd_port(S_CNT,  8'h00, "R1 count lo");
    rd_port(S_STAT, 8'h00, "R1 status");

    // table: R2 byte pointer, R3 readback, R4 pages, R9 idle status
    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][20:19] == OP_W) wr_port(VEC[i][18:16], VEC[i][15:8]);
      else rd_port(VEC[i][18:16], VEC[i][7:0], $sformatf("R2/R3/R4 vec %0d", i));
    end

    // R5 mode for another channel is ignored, R6 foreign unmask ignored
    wr_port(S_MODE, 8'h45);
    wr_port(S_MASK, 8'h02);
    @(negedge clk); chk("R5 foreign mode ignored", 32'(mem_req), 0);
    wr_port(S_MASK, 8'h06);
    wr_port(S_MODE, 8'h46);
    wr_port(S_MASK, 8'h01);
    @(negedge clk); chk("R6 foreign unmask ignored", 32'(mem_req), 0);
    wr_port(S_MASK, 8'h02);
    @(negedge clk);
    chk("R7 request raised", 32'(mem_req), 1);
    chk("R5 0x46 to memory", 32'(mem_wr), 1);
    chk("R7 full address", mem_addr, 32'hCDAB1278);

    // R7 steps: count 3 gives 4 bytes
    step_once("R7 step 1");
    step_once("R7 step 2");
    step_once("R7 step 3");
    @(negedge clk); chk("R7 address advanced", mem_addr, 32'hCDAB127B);
    chk("R8 no tc before last", 32'(tc), 0);

    // R9 + R8 same cycle: status read with the terminal step
    @(negedge clk);
    mem_ack = 1'b1; port_sel = S_STAT; port_rd = 1'b1;
    #1;
    chk("R9 read during tc shows old", 32'(port_rdata), 0);
    chk("R8 tc pulse", 32'(tc), 1);
    @(posedge clk); #1;
    mem_ack = 1'b0; port_rd = 1'b0;
    @(negedge clk); chk("R8 self mask", 32'(mem_req), 0);
    rd_port(S_STAT, 8'h04, "R9 flag survived");
    rd_port(S_STAT, 8'h00, "R9 read clears");
    wr_port(S_FLIP, 8'h00);
    rd_port(S_ADDR, 8'h7C, "R8 addr lo after 4");
    rd_port(S_ADDR, 8'h12, "R7 addr hi after 4");
    rd_port(S_CNT,  8'hFF, "R8 count lo wrapped");
    rd_port(S_CNT,  8'hFF, "R8 count hi wrapped");

    // R10 host count write while mem_ack held
    wr_port(S_MODE, 8'h4A);
    wr_port(S_MASK, 8'h02);
    wr_port(S_FLIP, 8'h00);
    @(negedge clk);
    mem_ack = 1'b1; port_sel = S_CNT; port_wdata = 8'h01; port_wr = 1'b1;
    #1 chk("R10 held during access", 32'(mem_req), 0);
    @(posedge clk); #1 port_wr = 1'b0; mem_ack = 1'b0;
    wr_port(S_CNT, 8'h00);
    wr_port(S_FLIP, 8'h00);
    rd_port(S_CNT, 8'h01, "R10 count unchanged lo");
    rd_port(S_CNT, 8'h00, "R10 count unchanged hi");
    @(negedge clk); chk("R5 0x4A from memory", 32'(mem_wr), 0);
    step_once("R7 step after 4A");

    // R7 address wrap keeps pages; count hits 0 -> terminal
    wr_port(S_FLIP, 8'h00);
    wr_port(S_ADDR, 8'hFF);
    wr_port(S_ADDR, 8'hFF);
    @(negedge clk); chk("R7 addr at top", mem_addr, 32'hCDABFFFF);
    step_once("R8 terminal step");
    @(negedge clk); chk("R7 wrap keeps page", mem_addr, 32'hCDAB0000);
    rd_port(S_STAT, 8'h04, "R8 status flag");

    // R6 mask bit set masks
    wr_port(S_MASK, 8'h02);
    @(negedge clk); chk("R6 unmask", 32'(mem_req), 1);
    wr_port(S_MASK, 8'h06);
    @(negedge clk); chk("R6 mask", 32'(mem_req), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule